// File: doc/BRIEF.md
# Chainable TDM Serial Audio Port

This block is the slave side of a codec's serial port on a time-division bus that several devices share. All timing is counted in periods of the serial bit clock `clk`, which runs at the bus bit rate. Each device on the bus owns one group of 64 consecutive bit periods per frame, made of eight 8-bit slots. A device learns that its group is next from a grant input. When it has used its group, it hands the grant on through a grant output to the next device in the chain. The first device in a chain ties its grant input to the frame sync.

A mode input selects one of two word layouts. In control mode, a received word is captured whole into a 64-bit control register. The low 32 bits, which hold the settings, cannot be written in this mode and are only read back. In data mode, a received word carries a left sample, a right sample and a new value for the settings. The outgoing word carries the two parallel input samples and a status field. Each time the mode input rises, a calibration window opens and stays open for 194 frames. While it is open, the received samples are muted and a busy flag is set in the status field.

Top module: `tdm_serial_port`

## Requirements
- R1: After reset, `sdout_oe`, `ts_out`, `rx_valid` and `cal_busy` are low, and `rx_left`, `rx_right`, `ctrl_word` and `settings` are all zero.
- R2: The device owns the 64 bit periods that start with the first period in which `ts_in` is low after being high. A grant that arrives while the device already owns the bus is ignored. `sdout_oe` is high in exactly the owned periods, and `sdout` is 0 outside them.
- R3: `ts_out` is high only in the 64th owned period, and only for that one period.
- R4: Words are sent and received MSB first. In owned period k (k = 0..63), `sdout` carries word bit 63-k and `sdin` is taken as word bit 63-k.
- R5: In data mode, the transmitted word is laid out as follows: bits 63:48 hold `tx_left` and bits 47:32 hold `tx_right`. Bits 31:0 hold the status field, where bit 31 is `cal_busy` and bits 30:0 are `settings[30:0]`.
- R6: In data mode, a received word is committed in the period after the last owned period. Bits 63:48 go to `rx_left`, bits 47:32 go to `rx_right` and bits 31:0 go to `settings`. `rx_valid` is high for that one period.
- R7: In control mode, a received word is committed whole to `ctrl_word`, and `rx_valid` pulses in the same way as in data mode. `settings`, `rx_left` and `rx_right` keep their values.
- R8: In control mode, the transmitted word is `ctrl_word[63:32]` followed by the 32-bit status field, laid out as in R5.
- R9: When `dc_mode` rises, `cal_busy` goes high in the next period. It stays high until 194 frame starts (falling edges of `fsync`) have been counted, and it drops after the 194th.
- R10: A data-mode word committed while `cal_busy` is high writes zeros to `rx_left` and `rx_right`. It still writes `settings`.
- R11: When `ts_in` is tied to `fsync` and held high for several periods, ownership starts at the first low period, which is also the frame start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial bit clock; inputs are sampled on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| fsync | input | 1 | Frame sync; a frame starts at its falling edge |
| ts_in | input | 1 | Slot grant from the previous device, or the frame sync for the first device |
| dc_mode | input | 1 | 0 = control mode, 1 = data mode |
| sdin | input | 1 | Serial data from the bus |
| sdout | output | 1 | Serial data to the bus; valid only while `sdout_oe` is high |
| sdout_oe | output | 1 | Drive enable for `sdout`; when low, the pin is high impedance |
| ts_out | output | 1 | Grant handed to the next device in the chain |
| tx_left | input | 16 | Left sample to transmit |
| tx_right | input | 16 | Right sample to transmit |
| rx_left | output | 16 | Last committed left sample |
| rx_right | output | 16 | Last committed right sample |
| rx_valid | output | 1 | One-period strobe when a word is committed |
| ctrl_word | output | 64 | Control register written in control mode |
| settings | output | 32 | Settings register, written only in data mode |
| cal_busy | output | 1 | Calibration window open |

## Verification
The properties rely on a few things about the bus. The previous device does not grant again while this device owns the bus. `dc_mode` is low through reset. Frames are at least three periods long. The bench drives every input on the falling clock edge, so the values are stable at the sampling edge. It grants only after at least one idle period and never toggles `fsync` during an owned word. The calibration window is counted down with bare three-period frames that carry no grant, so no word is moved during the count.

// File: rtl/tdm_port_pkg.sv
`timescale 1ns/1ps
package tdm_port_pkg;
   typedef enum logic {
      MODE_CTRL = 1'b0,
      MODE_DATA = 1'b1
   } port_mode_e;
endpackage

// File: rtl/tdm_slot_tracker.sv
`timescale 1ns/1ps
// Finds the start of this device's slot group from the falling grant
// and counts the owned bit periods.
module tdm_slot_tracker #(
   parameter int unsigned WORD_BITS = 64
) (
   input  logic clk,
   input  logic rst_n,
   input  logic grant_in,
   output logic start,
   output logic own,
   output logic last
);
   localparam int unsigned CW = $clog2(WORD_BITS);
   localparam logic [CW-1:0] LAST_IDX = CW'(WORD_BITS - 1);

   logic          grant_q;
   logic          busy_q;
   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         grant_q <= 1'b0;
         busy_q  <= 1'b0;
         cnt_q   <= '0;
      end else begin
         grant_q <= grant_in;
         if (start) begin
            busy_q <= 1'b1;
            cnt_q  <= CW'(1);
         end else if (busy_q) begin
            if (cnt_q == LAST_IDX) begin
               busy_q <= 1'b0;
               cnt_q  <= '0;
            end else begin
               cnt_q <= cnt_q + CW'(1);
            end
         end
      end
   end

   // a grant that falls while the group is already owned is ignored
   assign start = grant_q & ~grant_in & ~busy_q;
   assign own   = start | busy_q;
   assign last  = busy_q & (cnt_q == LAST_IDX);
endmodule

// File: rtl/tdm_word_shifter.sv
`timescale 1ns/1ps
// Parallel-to-serial and serial-to-parallel conversion for one word.
module tdm_word_shifter #(
   parameter int unsigned WORD_BITS = 64,
   parameter bit          MSB_FIRST = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 start,
   input  logic                 own,
   input  logic                 sdin,
   input  logic [WORD_BITS-1:0] tx_word,
   output logic                 sdout,
   output logic [WORD_BITS-1:0] rx_word
);
   logic [WORD_BITS-1:0] tx_ord;
   logic [WORD_BITS-1:0] rx_ord;
   logic [WORD_BITS-1:0] tx_sr;
   logic [WORD_BITS-2:0] rx_sr;

   generate
      if (MSB_FIRST) begin : g_msb
         assign tx_ord  = tx_word;
         assign rx_word = rx_ord;
      end else begin : g_lsb
         for (genvar i = 0; i < WORD_BITS; i++) begin : g_rev
            assign tx_ord[i]  = tx_word[WORD_BITS-1-i];
            assign rx_word[i] = rx_ord[WORD_BITS-1-i];
         end
      end
   endgenerate

   assign rx_ord = {rx_sr, sdin};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tx_sr <= '0;
         rx_sr <= '0;
      end else begin
         if (start) begin
            tx_sr <= {tx_ord[WORD_BITS-2:0], 1'b0};
         end else if (own) begin
            tx_sr <= {tx_sr[WORD_BITS-2:0], 1'b0};
         end
         if (own) begin
            rx_sr <= rx_ord[WORD_BITS-2:0];
         end
      end
   end

   // first bit comes straight from the word, the rest from the register
   assign sdout = own ? (start ? tx_ord[WORD_BITS-1] : tx_sr[WORD_BITS-1]) : 1'b0;
endmodule

// File: rtl/tdm_cal_window.sv
`timescale 1ns/1ps
// Opens a window on each rising mode input; closes after N frame starts.
module tdm_cal_window #(
   parameter int unsigned CAL_FRAMES = 194
) (
   input  logic clk,
   input  logic rst_n,
   input  logic mode_in,
   input  logic frame_tick,
   output logic busy
);
   localparam int unsigned CW = $clog2(CAL_FRAMES + 1);

   logic          mode_q;
   logic [CW-1:0] left_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode_q <= 1'b0;
         left_q <= '0;
      end else begin
         mode_q <= mode_in;
         if (mode_in & ~mode_q) begin
            left_q <= CW'(CAL_FRAMES);
         end else if (frame_tick && (left_q != '0)) begin
            left_q <= left_q - CW'(1);
         end
      end
   end

   assign busy = (left_q != '0);
endmodule

// File: rtl/tdm_serial_port.sv
`timescale 1ns/1ps
module tdm_serial_port #(
   parameter int unsigned SLOT_BITS   = 8,
   parameter int unsigned SLOTS       = 8,
   parameter int unsigned SAMPLE_BITS = 16,
   parameter int unsigned CAL_FRAMES  = 194,
   parameter bit          MSB_FIRST   = 1'b1,
   localparam int unsigned WORD_BITS  = SLOT_BITS * SLOTS,
   localparam int unsigned STAT_BITS  = WORD_BITS - 2 * SAMPLE_BITS
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   fsync,
   input  logic                   ts_in,
   input  logic                   dc_mode,
   input  logic                   sdin,
   output logic                   sdout,
   output logic                   sdout_oe,
   output logic                   ts_out,
   input  logic [SAMPLE_BITS-1:0] tx_left,
   input  logic [SAMPLE_BITS-1:0] tx_right,
   output logic [SAMPLE_BITS-1:0] rx_left,
   output logic [SAMPLE_BITS-1:0] rx_right,
   output logic                   rx_valid,
   output logic [WORD_BITS-1:0]   ctrl_word,
   output logic [STAT_BITS-1:0]   settings,
   output logic                   cal_busy
);
   import tdm_port_pkg::*;

   generate
      if (SLOTS < 2) begin : g_bad_slots
         $error("tdm_serial_port: SLOTS must be at least 2");
      end
      if (2 * SAMPLE_BITS + 2 > WORD_BITS) begin : g_bad_split
         $error("tdm_serial_port: word too short for two samples and status");
      end
      if (CAL_FRAMES < 1) begin : g_bad_cal
         $error("tdm_serial_port: CAL_FRAMES must be at least 1");
      end
   endgenerate

   logic                 fs_q;
   logic                 frame_tick;
   logic                 start;
   logic                 own;
   logic                 last;
   logic                 data_mode;
   logic [STAT_BITS-1:0] status;
   logic [WORD_BITS-1:0] tx_word;
   logic [WORD_BITS-1:0] rx_word;
   logic [WORD_BITS-1:0] ctrl_q;
   logic [STAT_BITS-1:0] settings_q;

   always_ff @(posedge clk) begin
      if (!rst_n) fs_q <= 1'b0;
      else        fs_q <= fsync;
   end
   assign frame_tick = fs_q & ~fsync;

   tdm_slot_tracker #(.WORD_BITS(WORD_BITS)) u_slots (
      .clk      (clk),
      .rst_n    (rst_n),
      .grant_in (ts_in),
      .start    (start),
      .own      (own),
      .last     (last)
   );

   tdm_cal_window #(.CAL_FRAMES(CAL_FRAMES)) u_cal (
      .clk        (clk),
      .rst_n      (rst_n),
      .mode_in    (dc_mode),
      .frame_tick (frame_tick),
      .busy       (cal_busy)
   );

   assign data_mode = (port_mode_e'(dc_mode) == MODE_DATA);
   assign status    = {cal_busy, settings_q[STAT_BITS-2:0]};
   assign tx_word   = data_mode ? {tx_left, tx_right, status}
                                : {ctrl_q[WORD_BITS-1 -: 2*SAMPLE_BITS], status};

   tdm_word_shifter #(.WORD_BITS(WORD_BITS), .MSB_FIRST(MSB_FIRST)) u_shift (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (start),
      .own     (own),
      .sdin    (sdin),
      .tx_word (tx_word),
      .sdout   (sdout),
      .rx_word (rx_word)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rx_valid   <= 1'b0;
         rx_left    <= '0;
         rx_right   <= '0;
         ctrl_q     <= '0;
         settings_q <= '0;
      end else begin
         rx_valid <= last;
         if (last) begin
            if (data_mode) begin
               rx_left    <= cal_busy ? '0 : rx_word[WORD_BITS-1 -: SAMPLE_BITS];
               rx_right   <= cal_busy ? '0 : rx_word[WORD_BITS-SAMPLE_BITS-1 -: SAMPLE_BITS];
               settings_q <= rx_word[STAT_BITS-1:0];
            end else begin
               ctrl_q <= rx_word;
            end
         end
      end
   end

   assign sdout_oe  = own;
   assign ts_out    = last;
   assign ctrl_word = ctrl_q;
   assign settings  = settings_q;
endmodule

// File: rtl/tdm_serial_port_chk.sv
`timescale 1ns/1ps
module tdm_serial_port_chk #(
   parameter int unsigned SAMPLE_BITS = 16,
   parameter int unsigned STAT_BITS   = 32
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic                   dc_mode,
   input logic                   sdout_oe,
   input logic                   ts_out,
   input logic                   rx_valid,
   input logic                   cal_busy,
   input logic [SAMPLE_BITS-1:0] rx_left,
   input logic [SAMPLE_BITS-1:0] rx_right,
   input logic [STAT_BITS-1:0]   settings
);
   // R2: the grant is handed on only while this device drives the bus
   assert_tsout_owned_R2: assert property (@(posedge clk) disable iff (!rst_n)
      ts_out |-> sdout_oe);

   // R3: the grant output is a single-period pulse
   assert_tsout_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ts_out |=> !ts_out);

   // R6: a commit strobe follows the last owned period
   assert_commit_after_last_R6: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid |-> $past(ts_out));

   // R7: settings change only through a data-mode commit
   assert_settings_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(dc_mode) |-> $stable(settings));

   // R9: entering data mode opens the calibration window
   assert_cal_open_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(dc_mode) |=> cal_busy);

   // R10: samples committed inside the window are muted
   assert_mute_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_valid && $past(cal_busy) && $past(dc_mode)) |-> (rx_left == '0 && rx_right == '0));
endmodule

bind tdm_serial_port tdm_serial_port_chk #(
   .SAMPLE_BITS (SAMPLE_BITS),
   .STAT_BITS   (STAT_BITS)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .dc_mode  (dc_mode),
   .sdout_oe (sdout_oe),
   .ts_out   (ts_out),
   .rx_valid (rx_valid),
   .cal_busy (cal_busy),
   .rx_left  (rx_left),
   .rx_right (rx_right),
   .settings (settings)
);

// File: tb/sim_tdm_serial_port.sv
`timescale 1ns/1ps
module sim_tdm_serial_port;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        fsync = 1'b0;
   logic        ts_in = 1'b0;
   logic        dc_mode = 1'b0;
   logic        sdin = 1'b0;
   logic        sdout, sdout_oe, ts_out, rx_valid, cal_busy;
   logic [15:0] tx_left = 16'hA5C3;
   logic [15:0] tx_right = 16'h0F1E;
   logic [15:0] rx_left, rx_right;
   logic [63:0] ctrl_word;
   logic [31:0] settings;

   int n_checks = 0;
   int n_err = 0;

   logic        s_sdout, s_oe, s_ts, s_valid;
   logic [63:0] g_dout;
   int          g_bad_pre, g_bad_oe, g_bad_ts;
   logic        g_v1, g_v2, g_oe_after;

   always #10 clk = ~clk;

   tdm_serial_port u0 (
      .clk(clk), .rst_n(rst_n), .fsync(fsync), .ts_in(ts_in), .dc_mode(dc_mode),
      .sdin(sdin), .sdout(sdout), .sdout_oe(sdout_oe), .ts_out(ts_out),
      .tx_left(tx_left), .tx_right(tx_right), .rx_left(rx_left), .rx_right(rx_right),
      .rx_valid(rx_valid), .ctrl_word(ctrl_word), .settings(settings), .cal_busy(cal_busy)
   );

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // one bit period: drive on the falling edge, sample just after it
   task automatic period(input logic f, input logic t, input logic d);
      @(negedge clk);
      fsync = f; ts_in = t; sdin = d;
      #1;
      s_sdout = sdout; s_oe = sdout_oe; s_ts = ts_out; s_valid = rx_valid;
   endtask

   task automatic frame();
      period(1'b1, 1'b0, 1'b0);
      period(1'b0, 1'b0, 1'b0);
      period(1'b0, 1'b0, 1'b0);
   endtask

   task automatic run_word(input logic [63:0] din, input int hi, input logic tie);
      g_bad_pre = 0; g_bad_oe = 0; g_bad_ts = 0;
      for (int i = 0; i < hi; i++) begin
         period(tie, 1'b1, 1'b0);
         if (s_oe || s_ts) g_bad_pre++;
      end
      for (int k = 0; k < 64; k++) begin
         period(1'b0, 1'b0, din[63-k]);
         g_dout[63-k] = s_sdout;
         if (!s_oe) g_bad_oe++;
         if (s_ts !== (k == 63)) g_bad_ts++;
      end
      period(1'b0, 1'b0, 1'b0);
      g_v1 = s_valid; g_oe_after = s_oe;
      period(1'b0, 1'b0, 1'b0);
      g_v2 = s_valid;
   endtask

   task automatic check_framing(input string tag);
      chk({"R2 no drive before grant ", tag}, 64'(g_bad_pre), 64'd0);
      chk({"R2 drive in owned periods ", tag}, 64'(g_bad_oe), 64'd0);
      chk({"R2 release after group ", tag}, 64'(g_oe_after), 64'd0);
      chk({"R3 ts_out only in last period ", tag}, 64'(g_bad_ts), 64'd0);
      chk({"R6 rx_valid strobe ", tag}, {62'd0, g_v1, g_v2}, 64'd2);
   endtask

   task automatic t_reset();
      period(1'b0, 1'b0, 1'b0);
      chk("R1 sdout_oe", 64'(s_oe), 64'd0);
      chk("R1 ts_out", 64'(s_ts), 64'd0);
      chk("R1 rx_valid", 64'(s_valid), 64'd0);
      chk("R1 cal_busy", 64'(cal_busy), 64'd0);
      chk("R1 registers", {rx_left, rx_right, settings}, 64'd0);
      chk("R1 ctrl_word", ctrl_word, 64'd0);
   endtask

   task automatic t_control();
      run_word(64'h1234_5678_9ABC_DEF0, 1, 1'b0);
      check_framing("ctrl A");
      chk("R7 ctrl_word captured", ctrl_word, 64'h1234_5678_9ABC_DEF0);
      chk("R7 settings read-only", 64'(settings), 64'd0);
      chk("R7 samples kept", {32'd0, rx_left, rx_right}, 64'd0);
      chk("R8 R4 readback of empty ctrl", g_dout, 64'd0);
      run_word(64'hFEDC_BA98_7654_3210, 1, 1'b0);
      chk("R8 R4 ctrl readback", g_dout, 64'h1234_5678_0000_0000);
      chk("R7 ctrl_word second", ctrl_word, 64'hFEDC_BA98_7654_3210);
   endtask

   task automatic t_calibration();
      dc_mode = 1'b1;
      period(1'b0, 1'b0, 1'b0);
      period(1'b0, 1'b0, 1'b0);
      chk("R9 window opens", 64'(cal_busy), 64'd1);
      run_word({16'h1357, 16'h2468, 32'h0BAD_F00D}, 1, 1'b0);
      check_framing("cal word");
      chk("R5 R4 status busy bit", g_dout, {16'hA5C3, 16'h0F1E, 32'h8000_0000});
      chk("R10 muted samples", {32'd0, rx_left, rx_right}, 64'd0);
      chk("R10 settings still written", 64'(settings), 64'h0BAD_F00D);
      for (int f = 0; f < 193; f++) frame();
      chk("R9 busy after 193 frames", 64'(cal_busy), 64'd1);
      frame();
      chk("R9 closed after 194 frames", 64'(cal_busy), 64'd0);
   endtask

   task automatic t_data();
      run_word({16'h8001, 16'h7FFE, 32'h4000_00A5}, 3, 1'b1);
      check_framing("tied grant");
      chk("R11 R5 tied-grant tx word", g_dout, {16'hA5C3, 16'h0F1E, 32'h0BAD_F00D});
      chk("R11 R6 samples", {32'd0, rx_left, rx_right}, 64'h8001_7FFE);
      chk("R6 settings", 64'(settings), 64'h4000_00A5);
      run_word({16'hFFFF, 16'h0000, 32'hC000_0001}, 1, 1'b0);
      chk("R5 status readback", g_dout, {16'hA5C3, 16'h0F1E, 32'h4000_00A5});
      chk("R6 samples second", {32'd0, rx_left, rx_right}, 64'hFFFF_0000);
      run_word({16'h4321, 16'h8765, 32'h0000_0000}, 1, 1'b0);
      chk("R5 bit31 replaced by busy", g_dout, {16'hA5C3, 16'h0F1E, 32'h4000_0001});
      chk("R6 samples third", {32'd0, rx_left, rx_right}, 64'h4321_8765);
   endtask

   task automatic t_back_to_control();
      dc_mode = 1'b0;
      period(1'b0, 1'b0, 1'b0);
      run_word(64'h0F0F_0F0F_F0F0_F0F1, 1, 1'b0);
      check_framing("ctrl C");
      chk("R8 ctrl readback after data", g_dout, 64'hFEDC_BA98_0000_0000);
      chk("R7 settings unchanged", 64'(settings), 64'd0);
      chk("R7 samples unchanged", {32'd0, rx_left, rx_right}, 64'h4321_8765);
      chk("R7 ctrl_word third", ctrl_word, 64'h0F0F_0F0F_F0F0_F0F1);
      chk("R9 no window in control mode", 64'(cal_busy), 64'd0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_control();
      t_calibration();
      t_data();
      t_back_to_control();
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
      $finish;
   end

   initial begin
      #4_000_000;
      n_checks++;
      n_err++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
      $finish;
   end
endmodule